// File: doc/BRIEF.md
# Accumulator Arithmetic Unit with Condition Flags

This block is the arithmetic stage of an 8-bit accumulator processor. Each cycle it takes the accumulator value, one operand byte and a 3-bit operation code. From these it produces an 8-bit result and a new set of five condition flags. The operand byte may be a register, a memory byte addressed by the pointer pair, or an immediate byte, and the unit treats all three the same way. Operand fetch, decode and the write-back of the result stay outside the block.

The operations are add, add with carry, subtract, subtract with borrow, increment, decrement and decimal adjust. The result, the new flag values and a per-flag write-enable mask are all combinational outputs. A clocked flag register inside the block keeps the flags between operations. It loads the enabled flags when the operation strobe is high, so carry-in, borrow-in and the decimal-adjust inputs always come from the previous operation.

Top module: `acc_alu`

## Requirements
- R1: With op_sel 0 (add) the result is acc_in + opnd_in. With op_sel 1 (add with carry) the result is acc_in + opnd_in + stored CY. In both cases, CY is the carry out of bit 7 and AC is the carry out of bit 3.
- R2: With op_sel 2 (subtract) the result is acc_in − opnd_in modulo 256. With op_sel 3 (subtract with borrow) the result is acc_in − opnd_in − stored CY. CY is set when the true difference is negative. AC is set when the low-nibble difference needs a borrow into bit 4.
- R3: With op_sel 4 (increment) the result is opnd_in + 1, and with op_sel 5 (decrement) it is opnd_in − 1. AC is the carry out of bit 3 (increment) or the borrow into bit 4 (decrement). CY in flags_new equals stored CY, and the stored CY does not change.
- R4: With op_sel 6 (decimal adjust) the unit adds a correction to acc_in.
  - The correction includes 06h when the low nibble is above 9 or stored AC is 1.
  - It includes 60h when any of these holds: the high nibble is above 9, the high nibble is 9 and the low nibble is above 9, or stored CY is 1.
  - When a decimal adjust follows the add of two 2-digit BCD values, the result is the BCD form of their sum modulo 100.
- R5: After decimal adjust, CY is 1 exactly when the 60h correction was applied. AC is the carry out of bit 3 of the correction addition.
- R6: The flag vector has bit 0 = CY, bit 1 = P, bit 2 = AC, bit 3 = Z and bit 4 = S.
  - S is result bit 7.
  - Z is 1 when the result is zero.
  - P is 1 when the result has an even number of ones.
- R7: flags_q changes at a rising clk edge only when op_valid is high. It then loads flags_new in the bits where flag_we is 1 and keeps its value in every other bit.
- R8: rst is synchronous and active high, and it clears flags_q to 0.
- R9: op_sel 7 is a hold code. The result equals acc_in, flags_new equals flags_q, and a strobed hold code leaves flags_q unchanged.
- R10: flag_we is 11111b for op_sel 0, 1, 2, 3 and 6. It is 11110b for op_sel 4 and 5, and 00000b for op_sel 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset of the flag register |
| op_valid | input | 1 | Strobe; the flag register loads at the next edge when high |
| op_sel | input | 3 | Operation code (0 add, 1 add with carry, 2 sub, 3 sub with borrow, 4 inc, 5 dec, 6 decimal adjust, 7 hold) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Operand byte (register, memory or immediate) |
| result | output | 8 | Arithmetic result |
| flags_new | output | 5 | Computed flags {S,Z,AC,P,CY} |
| flag_we | output | 5 | Per-flag write-enable mask |
| flags_q | output | 5 | Stored flags {S,Z,AC,P,CY} |

## Verification
The digit check in the decimal adjuster assumes a particular input state.
- The assumed state is left by a BCD addition: the low nibble of acc_in is at most 9 with AC clear, or at most 3 with AC set.
- The stimulus keeps to this by sending the decimal-adjust code only right after a strobed add of two 2-digit BCD values, with acc_in equal to that sum.
- As a result, AC and CY in the flag register come from that addition.

The wrap checks in the adder hold for any byte pair, so the binary operations are swept over every operand pair with both carry-in values. The flag-register checks assume that op_sel is never unknown while op_valid is high after reset.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;
   localparam int FLAG_N = 5;
   localparam int FL_CY  = 0;
   localparam int FL_P   = 1;
   localparam int FL_AC  = 2;
   localparam int FL_Z   = 3;
   localparam int FL_S   = 4;

   typedef enum logic [2:0] {
      OP_ADD  = 3'd0,
      OP_ADC  = 3'd1,
      OP_SUB  = 3'd2,
      OP_SBB  = 3'd3,
      OP_INC  = 3'd4,
      OP_DEC  = 3'd5,
      OP_DAA  = 3'd6,
      OP_HOLD = 3'd7
   } alu_op_e;
endpackage

// File: rtl/acc_addsub.sv
module acc_addsub #(
   parameter int W     = 8,
   parameter int NIB_W = 4
) (
   input  logic [W-1:0] a,
   input  logic [W-1:0] b,
   input  logic         cin,
   input  logic         sub,
   output logic [W-1:0] sum,
   output logic         c_hi,
   output logic         c_nib
);
   localparam int NIB_EXT = NIB_W + 1;

   if (NIB_W < 1 || NIB_W >= W) begin : g_bad_nib
      $error("acc_addsub: NIB_W must lie between 1 and W-1");
   end

   logic [W-1:0]       b_eff;
   logic               c_eff;
   logic [W:0]         full;
   logic [NIB_EXT-1:0] low;

   always_comb begin
      b_eff = sub ? ~b : b;
      c_eff = sub ? ~cin : cin;
      full  = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, c_eff};
      low   = {1'b0, a[NIB_W-1:0]} + {1'b0, b_eff[NIB_W-1:0]} + {{NIB_W{1'b0}}, c_eff};
      sum   = full[W-1:0];
      c_hi  = full[W] ^ sub;
      c_nib = low[NIB_W] ^ sub;
   end

   // R1
   always_comb begin
      if (!sub && c_hi)
         add_wrap_chk: assert (sum <= a) else $error("add carry without wrap");
   end

   // R2
   always_comb begin
      if (sub && c_hi)
         sub_wrap_chk: assert (sum >= a) else $error("borrow without wrap");
   end
endmodule

// File: rtl/acc_daa.sv
module acc_daa #(
   parameter int W = 8
) (
   input  logic [W-1:0] acc,
   input  logic         ac_in,
   input  logic         cy_in,
   output logic [W-1:0] adj,
   output logic         ac_out,
   output logic         cy_out
);
   localparam int NIB_W   = W / 2;
   localparam int DIG_MAX = 9;
   localparam logic [NIB_W-1:0] FIX = NIB_W'(6);
   localparam logic [NIB_W-1:0] LIM = NIB_W'(DIG_MAX);

   if (W != 8) begin : g_bad_w
      $error("acc_daa: two decimal digits need an 8-bit accumulator");
   end

   logic [NIB_W-1:0] lo, hi;
   logic             lo_fix, hi_fix;
   logic [W-1:0]     corr;
   logic             add_carry;

   always_comb begin
      lo     = acc[NIB_W-1:0];
      hi     = acc[W-1:NIB_W];
      lo_fix = (lo > LIM) || ac_in;
      hi_fix = (hi > LIM) || ((hi == LIM) && (lo > LIM)) || cy_in;
      corr   = {(hi_fix ? FIX : '0), (lo_fix ? FIX : '0)};
   end

   acc_addsub #(.W(W), .NIB_W(NIB_W)) u_fix_add (
      .a     (acc),
      .b     (corr),
      .cin   (1'b0),
      .sub   (1'b0),
      .sum   (adj),
      .c_hi  (add_carry),
      .c_nib (ac_out)
   );

   assign cy_out = hi_fix | add_carry;

   // R4
   always_comb begin
      if ((!ac_in && (lo <= LIM)) || (ac_in && (lo <= NIB_W'(3))))
         daa_low_digit_chk: assert (adj[NIB_W-1:0] <= LIM) else $error("low digit not decimal");
   end
endmodule

// File: rtl/acc_flaggen.sv
module acc_flaggen #(
   parameter int W = 8
) (
   input  logic [W-1:0] r,
   output logic         sign,
   output logic         zero,
   output logic         par_even
);
   logic [W:0] chain;
   assign chain[0] = 1'b1;

   for (genvar i = 0; i < W; i++) begin : g_par
      assign chain[i+1] = chain[i] ^ r[i];
   end

   assign par_even = chain[W];
   assign zero     = ~|r;
   assign sign     = r[W-1];
endmodule

// File: rtl/acc_alu.sv
module acc_alu
   import acc_alu_pkg::*;
#(
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              op_valid,
   input  logic [2:0]        op_sel,
   input  logic [DATA_W-1:0] acc_in,
   input  logic [DATA_W-1:0] opnd_in,
   output logic [DATA_W-1:0] result,
   output logic [FLAG_N-1:0] flags_new,
   output logic [FLAG_N-1:0] flag_we,
   output logic [FLAG_N-1:0] flags_q
);
   localparam int NIB_W = DATA_W / 2;
   localparam logic [FLAG_N-1:0] WE_ALL  = '1;
   localparam logic [FLAG_N-1:0] WE_NOCY = WE_ALL & ~(FLAG_N'(1) << FL_CY);

   if (DATA_W != 8) begin : g_bad_width
      $error("acc_alu: DATA_W must be 8");
   end

   alu_op_e op;
   assign op = alu_op_e'(op_sel);

   logic              incdec, ar_sub, ar_cin, ar_hi, ar_nib;
   logic [DATA_W-1:0] ar_a, ar_b, ar_sum;
   logic [DATA_W-1:0] daa_adj;
   logic              daa_ac, daa_cy;
   logic              f_s, f_z, f_p;

   always_comb begin
      incdec = (op == OP_INC) || (op == OP_DEC);
      ar_sub = (op == OP_SUB) || (op == OP_SBB) || (op == OP_DEC);
      ar_a   = incdec ? opnd_in : acc_in;
      ar_b   = incdec ? '0 : opnd_in;
      unique case (op)
         OP_ADC, OP_SBB: ar_cin = flags_q[FL_CY];
         OP_INC, OP_DEC: ar_cin = 1'b1;
         default:        ar_cin = 1'b0;
      endcase
   end

   acc_addsub #(.W(DATA_W), .NIB_W(NIB_W)) u_arith (
      .a     (ar_a),
      .b     (ar_b),
      .cin   (ar_cin),
      .sub   (ar_sub),
      .sum   (ar_sum),
      .c_hi  (ar_hi),
      .c_nib (ar_nib)
   );

   acc_daa #(.W(DATA_W)) u_daa (
      .acc    (acc_in),
      .ac_in  (flags_q[FL_AC]),
      .cy_in  (flags_q[FL_CY]),
      .adj    (daa_adj),
      .ac_out (daa_ac),
      .cy_out (daa_cy)
   );

   always_comb begin
      unique case (op)
         OP_DAA:  result = daa_adj;
         OP_HOLD: result = acc_in;
         default: result = ar_sum;
      endcase
   end

   acc_flaggen #(.W(DATA_W)) u_flags (
      .r        (result),
      .sign     (f_s),
      .zero     (f_z),
      .par_even (f_p)
   );

   always_comb begin
      flags_new = flags_q;
      flag_we   = '0;
      if (op != OP_HOLD) begin
         flags_new[FL_S] = f_s;
         flags_new[FL_Z] = f_z;
         flags_new[FL_P] = f_p;
         if (op == OP_DAA) begin
            flags_new[FL_AC] = daa_ac;
            flags_new[FL_CY] = daa_cy;
         end else begin
            flags_new[FL_AC] = ar_nib;
            flags_new[FL_CY] = incdec ? flags_q[FL_CY] : ar_hi;
         end
         flag_we = incdec ? WE_NOCY : WE_ALL;
      end
   end

   for (genvar i = 0; i < FLAG_N; i++) begin : g_flag_bit
      always_ff @(posedge clk) begin
         if (rst)
            flags_q[i] <= 1'b0;
         else if (op_valid && flag_we[i])
            flags_q[i] <= flags_new[i];
      end
   end

   // R7
   hold_when_idle_chk: assert property (@(posedge clk) disable iff (rst)
      !op_valid |=> $stable(flags_q));

   // R3
   incdec_keeps_cy_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && (op_sel == OP_INC || op_sel == OP_DEC)) |=> $stable(flags_q[FL_CY]));

   // R6
   zero_flag_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && flag_we[FL_Z]) |=> (flags_q[FL_Z] == ($past(result) == '0)));

   // R9
   hold_code_chk: assert property (@(posedge clk) disable iff (rst)
      (op_valid && op_sel == OP_HOLD) |=> $stable(flags_q));

   // R8
   reset_clear_chk: assert property (@(posedge clk)
      rst |=> (flags_q == '0));
endmodule

// File: tb/acc_alu_bench.sv
`timescale 1ns/1ps
module acc_alu_bench;
   logic       clk = 1'b0;
   logic       rst;
   logic       op_valid;
   logic [2:0] op_sel;
   logic [7:0] acc_in, opnd_in;
   logic [7:0] result;
   logic [4:0] flags_new, flag_we, flags_q;

   always #4 clk = ~clk;

   acc_alu u_acc_alu (
      .clk(clk), .rst(rst), .op_valid(op_valid), .op_sel(op_sel),
      .acc_in(acc_in), .opnd_in(opnd_in), .result(result),
      .flags_new(flags_new), .flag_we(flag_we), .flags_q(flags_q)
   );

   typedef struct {
      bit         reg_chk;
      string      req;
      logic [7:0] res;
      logic [4:0] fl;
      logic [4:0] we;
   } exp_t;

   exp_t sb[$];
   event ev;
   int   checks = 0;
   int   errors = 0;
   int   cycles = 0;
   logic [4:0] fq;

   function automatic logic [17:0] model(int op, int a, int b, logic [4:0] q);
      int  r, s, c, lo, hi, corr;
      bit  co, ao, par;
      logic [4:0] we;
      we = 5'b11111;
      c  = 0;
      r  = 0; co = 0; ao = 0;
      if (op == 7) return {a[7:0], q, 5'b00000};
      case (op)
         0, 1: begin
            c  = (op == 1) ? int'(q[0]) : 0;
            s  = a + b + c;
            r  = s % 256;
            co = (s > 255);
            ao = ((a % 16) + (b % 16) + c) > 15;
         end
         2, 3: begin
            c  = (op == 3) ? int'(q[0]) : 0;
            s  = a - b - c;
            r  = (s + 512) % 256;
            co = (s < 0);
            ao = ((a % 16) - (b % 16) - c) < 0;
         end
         4: begin
            r = (b + 1) % 256; co = q[0]; ao = (b % 16) == 15; we = 5'b11110;
         end
         5: begin
            r = (b + 255) % 256; co = q[0]; ao = (b % 16) == 0; we = 5'b11110;
         end
         default: begin
            lo = a % 16; hi = a / 16; corr = 0;
            if (lo > 9 || q[2]) corr += 6;
            if (hi > 9 || (hi == 9 && lo > 9) || q[0]) begin corr += 96; co = 1; end
            else co = 0;
            r  = (a + corr) % 256;
            ao = (lo + (corr % 16)) > 15;
         end
      endcase
      par = 1;
      for (int k = 0; k < 8; k++) if (((r >> k) & 1) == 1) par = ~par;
      return {r[7:0], (r >= 128), (r == 0), ao, par, co, we};
   endfunction

   task automatic push(bit regc, string req, logic [17:0] m);
      exp_t it;
      it.reg_chk = regc; it.req = req;
      it.res = m[17:10]; it.fl = m[9:5]; it.we = m[4:0];
      sb.push_back(it);
   endtask

   task automatic comb_vec(int op, int a, int b, string req);
      op_sel = 3'(op); acc_in = 8'(a); opnd_in = 8'(b);
      push(0, req, model(op, a, b, fq));
      #1 ->ev;
      #1;
   endtask

   task automatic reg_expect(string req);
      push(1, req, {8'h00, fq, 5'b00000});
      #1 ->ev;
   endtask

   task automatic clk_op(int op, int a, int b, string req);
      logic [17:0] m;
      @(negedge clk);
      op_sel = 3'(op); acc_in = 8'(a); opnd_in = 8'(b); op_valid = 1'b1;
      m = model(op, a, b, fq);
      push(0, req, m);
      #1 ->ev;
      @(posedge clk);
      fq = (fq & ~m[4:0]) | (m[9:5] & m[4:0]);
      @(negedge clk);
      op_valid = 1'b0;
      reg_expect("R7");
   endtask

   task automatic do_reset();
      @(negedge clk); rst = 1'b1;
      @(negedge clk); rst = 1'b0;
      fq = 5'b0;
      reg_expect("R8");
   endtask

   function automatic int to_bcd(int n);
      return (n / 10) * 16 + (n % 10);
   endfunction

   task automatic bcd_case(int x, int y);
      int a, b, s;
      logic [17:0] m;
      exp_t it;
      a = to_bcd(x); b = to_bcd(y); s = (a + b) % 256;
      clk_op(0, a, b, "R1");
      @(negedge clk);
      op_sel = 3'd6; acc_in = 8'(s); opnd_in = 8'h00; op_valid = 1'b1;
      m = model(6, s, 0, fq);
      it.reg_chk = 0; it.req = "R4 R5";
      it.res = 8'(to_bcd((x + y) % 100));
      it.fl = m[9:5]; it.fl[0] = ((x + y) >= 100);
      it.we = m[4:0];
      sb.push_back(it);
      #1 ->ev;
      @(posedge clk);
      fq = (fq & ~m[4:0]) | (m[9:5] & m[4:0]);
      @(negedge clk);
      op_valid = 1'b0;
      reg_expect("R5 R7");
   endtask

   task automatic finish_run();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin : monitor
      exp_t it;
      forever begin
         @(ev);
         it = sb.pop_front();
         checks++;
         if (it.reg_chk) begin
            if (flags_q !== it.fl) begin
               errors++;
               $display("FAIL %s flags_q actual %b expected %b", it.req, flags_q, it.fl);
            end
         end else if (result !== it.res || flags_new !== it.fl || flag_we !== it.we) begin
            errors++;
            $display("FAIL %s op %0d acc %h opnd %h: actual res %h fl %b we %b expected res %h fl %b we %b",
                     it.req, op_sel, acc_in, opnd_in, result, flags_new, flag_we,
                     it.res, it.fl, it.we);
         end
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles == 190000) begin
         errors++;
         $display("FAIL timeout (all requirements) cycles actual %0d expected below %0d", cycles, 190000);
         finish_run();
      end
   end

   initial begin : driver
      rst = 1'b1; op_valid = 1'b0; op_sel = 3'd0; acc_in = 8'h00; opnd_in = 8'h00;
      fq = 5'b0;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      reg_expect("R8");

      clk_op(0, 8'hFF, 8'h01, "R1 R6 R10");
      @(negedge clk);
      op_sel = 3'd2; acc_in = 8'h00; opnd_in = 8'h01;
      repeat (3) @(negedge clk);
      reg_expect("R7");
      do_reset();

      clk_op(0, 0, 0, "R1 R6");
      for (int a = 0; a < 256; a++) for (int b = 0; b < 256; b++) comb_vec(0, a, b, "R1 R6 R10");
      for (int a = 0; a < 256; a++) for (int b = 0; b < 256; b++) comb_vec(2, a, b, "R2 R6 R10");
      for (int a = 0; a < 256; a++) for (int b = 0; b < 256; b++) comb_vec(1, a, b, "R1 CY0");
      for (int a = 0; a < 256; a++) for (int b = 0; b < 256; b++) comb_vec(3, a, b, "R2 CY0");
      for (int b = 0; b < 256; b++) begin comb_vec(4, 0, b, "R3 R10"); comb_vec(5, 0, b, "R3"); end

      clk_op(0, 8'hFF, 8'h01, "R1");
      for (int a = 0; a < 256; a++) for (int b = 0; b < 256; b++) comb_vec(1, a, b, "R1 CY1");
      for (int a = 0; a < 256; a++) for (int b = 0; b < 256; b++) comb_vec(3, a, b, "R2 CY1");
      for (int b = 0; b < 256; b++) begin comb_vec(4, 0, b, "R3"); comb_vec(5, 0, b, "R3"); end
      clk_op(4, 0, 8'hFF, "R3");
      clk_op(5, 0, 8'h00, "R3");

      comb_vec(7, 8'h5A, 8'h33, "R9 R10");
      clk_op(7, 8'h00, 8'h00, "R9");

      bcd_case(36, 29);
      bcd_case(45, 55);
      bcd_case(99, 99);
      bcd_case(49, 49);
      for (int x = 0; x < 100; x += 3) for (int y = 0; y < 100; y += 7) bcd_case(x, y);

      do_reset();
      @(negedge clk);
      finish_run();
   end
endmodule